// File: doc/BRIEF.md
# Configurable Interrupt Router

This block takes three board-level interrupt sources (an experiment request, a power-fail warning and a spare request) and steers each one onto one of eight ISA interrupt request lines. A single 16-bit configuration word supplies all of the routing. For each source it holds a 3-bit line code and an enable bit. For the experiment source it also holds a choice between two physical inputs and a polarity control for one of them.

Each output line has a level and its own drive-enable. A line that no enabled source points at is left undriven, so other boards on the bus may share it. When two enabled sources point at the same line, their requests are ORed together.

A one-cycle clear strobe revokes the power-fail enable. The enable stays revoked until software writes the power-fail enable bit low and then high again.

All raw source inputs are resynchronized before they are routed. The line outputs come from flops, so they cannot glitch.

Top module: `irq_router`

## Requirements
- R1: An enabled source whose route code is c drives output bit c of `irq_level`/`irq_oe`. The ISA lines for codes 0..7 are IRQ 11, 10, 7, 6, 5, 4, 3 and 9, in that order.
- R2: A disabled source has no effect on any line. A line that no enabled source selects has its drive-enable low and its level low.
- R3: Configuration bit 3 picks the experiment input: 0 selects `bnc_irq_in`, 1 selects `alt_irq_in`.
- R4: Configuration bit 4 sets the sense of `bnc_irq_in` only: 0 means active-high, 1 means active-low. It does not alter `alt_irq_in`.
- R5: The power-fail source takes its route code from configuration bits [8:6] and is enabled by bit 9. The experiment source uses bits [2:0] and enable bit 5.
- R6: The spare source takes its route code from configuration bits [12:10] and is enabled by bit 13.
- R7: When two or more enabled sources share a line, that line's drive-enable is high and its level is the OR of their requests.
- R8: A one-cycle pulse on `pf_en_clr` revokes the power-fail enable, so the power-fail line is neither driven nor asserted. The enable stays revoked while bit 9 stays high, and is restored only after bit 9 has been seen low. A pulse that arrives while bit 9 is low still takes effect. The outputs reflect the clear two rising edges after the pulse.
- R9: A change on a raw source input reaches the outputs on the third rising edge after it. A change of the configuration word reaches them on the first.
- R10: Synchronous reset drives all levels and drive-enables low and cancels any revoked power-fail enable.
- R11: A line's level is never high while its drive-enable is low.
- R12: Configuration bits 15 and 14 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Routing configuration word |
| bnc_irq_in | input | 1 | Experiment input with selectable sense (asynchronous) |
| alt_irq_in | input | 1 | Alternate experiment input, active-high (asynchronous) |
| pf_irq_in | input | 1 | Power-fail request, active-high (asynchronous) |
| spare_irq_in | input | 1 | Spare request, active-high (asynchronous) |
| pf_en_clr | input | 1 | One-cycle strobe that revokes the power-fail enable |
| irq_level | output | 8 | Line levels, bit index = route code |
| irq_oe | output | 8 | Line drive-enables, bit index = route code |

## Verification
The bench builds the block with its default two-stage synchronizer. That makes the three-edge input latency and the two-edge clear latency exact, sampled cycle counts that the bench checks directly. Because the route codes are a fixed 3 bits wide, random configuration words reach all eight lines. They also produce frequent collisions of two or three sources on one line, and they toggle the two unused top bits. Directed sequences cover the clear strobe arriving while the enable bit is high and while it is low, the re-arming through a low enable bit, the polarity inversion, and the input swap.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int CFG_W      = 16;
    localparam int ROUTE_W    = 3;
    localparam int LINE_COUNT = 1 << ROUTE_W;
    localparam int SRC_COUNT  = 3;

    // Source slots
    localparam int SRC_EXP = 0;
    localparam int SRC_PF  = 1;
    localparam int SRC_SPR = 2;

    typedef struct packed {
        logic               en;
        logic [ROUTE_W-1:0] sel;
    } route_t;

    typedef struct packed {
        route_t exp_r;
        logic   exp_use_alt;
        logic   bnc_active_low;
        route_t pf_r;
        route_t spr_r;
    } cfg_t;

    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.exp_r.sel      = w[2:0];
        c.exp_use_alt    = w[3];
        c.bnc_active_low = w[4];
        c.exp_r.en       = w[5];
        c.pf_r.sel       = w[8:6];
        c.pf_r.en        = w[9];
        c.spr_r.sel      = w[12:10];
        c.spr_r.en       = w[13];
        return c;
    endfunction

    // ISA request number driven for a route code
    function automatic int unsigned code_to_isa(input logic [ROUTE_W-1:0] code);
        case (code)
            3'd7:    return 9;
            3'd6:    return 3;
            3'd5:    return 4;
            3'd4:    return 5;
            3'd3:    return 6;
            3'd2:    return 7;
            3'd1:    return 10;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q[0] <= din;
            for (int k = 1; k < STAGES; k++) begin
                q[k] <= q[k-1];
            end
        end
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cfg_t                 cfg_i,
    input  logic                 bnc_s,
    input  logic                 alt_s,
    input  logic                 pf_s,
    input  logic                 spr_s,
    input  logic                 pf_clr,
    output logic [SRC_COUNT-1:0] en_o,
    output logic [SRC_COUNT-1:0] act_o
);
    logic pf_revoked;
    logic exp_req;

    // Clear wins over a low enable bit in the same cycle
    always_ff @(posedge clk) begin
        if (rst)              pf_revoked <= 1'b0;
        else if (pf_clr)      pf_revoked <= 1'b1;
        else if (!cfg_i.pf_r.en) pf_revoked <= 1'b0;
    end

    always_comb begin
        exp_req = cfg_i.exp_use_alt ? alt_s : (bnc_s ^ cfg_i.bnc_active_low);
        en_o[SRC_EXP]  = cfg_i.exp_r.en;
        en_o[SRC_PF]   = cfg_i.pf_r.en & ~pf_revoked;
        en_o[SRC_SPR]  = cfg_i.spr_r.en;
        act_o[SRC_EXP] = en_o[SRC_EXP] & exp_req;
        act_o[SRC_PF]  = en_o[SRC_PF]  & pf_s;
        act_o[SRC_SPR] = en_o[SRC_SPR] & spr_s;
    end

    AST_PF_CLEAR_REVOKES: assert property (@(posedge clk) disable iff (rst)
        pf_clr |=> !en_o[SRC_PF]); // R8

    AST_ACT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (act_o & ~en_o) == '0); // R2
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
    import irq_route_pkg::*;
#(
    parameter int NSRC = SRC_COUNT,
    parameter int NLINE = LINE_COUNT
) (
    input  route_t [NSRC-1:0] routes_i,
    input  logic   [NSRC-1:0] en_i,
    input  logic   [NSRC-1:0] act_i,
    output logic   [NLINE-1:0] oe_o,
    output logic   [NLINE-1:0] lvl_o
);
    for (genvar ln = 0; ln < NLINE; ln++) begin : g_line
        logic hit_oe;
        logic hit_lvl;
        always_comb begin
            hit_oe  = 1'b0;
            hit_lvl = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                if (routes_i[s].sel == ROUTE_W'(ln)) begin
                    hit_oe  = hit_oe  | en_i[s];
                    hit_lvl = hit_lvl | act_i[s];
                end
            end
        end
        assign oe_o[ln]  = hit_oe;
        assign lvl_o[ln] = hit_lvl;
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic                  bnc_irq_in,
    input  logic                  alt_irq_in,
    input  logic                  pf_irq_in,
    input  logic                  spare_irq_in,
    input  logic                  pf_en_clr,
    output logic [LINE_COUNT-1:0] irq_level,
    output logic [LINE_COUNT-1:0] irq_oe
);
    localparam int RAW_W = 4;

    cfg_t                   cfg;
    logic [RAW_W-1:0]       raw_s;
    logic [SRC_COUNT-1:0]   src_en;
    logic [SRC_COUNT-1:0]   src_act;
    route_t [SRC_COUNT-1:0] routes;
    logic [LINE_COUNT-1:0]  nxt_oe;
    logic [LINE_COUNT-1:0]  nxt_lvl;

    assign cfg = decode_cfg(cfg_word);

    irq_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spare_irq_in, pf_irq_in, alt_irq_in, bnc_irq_in}),
        .dout (raw_s)
    );

    irq_src_cond u_cond (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .bnc_s  (raw_s[0]),
        .alt_s  (raw_s[1]),
        .pf_s   (raw_s[2]),
        .spr_s  (raw_s[3]),
        .pf_clr (pf_en_clr),
        .en_o   (src_en),
        .act_o  (src_act)
    );

    assign routes[SRC_EXP] = cfg.exp_r;
    assign routes[SRC_PF]  = cfg.pf_r;
    assign routes[SRC_SPR] = cfg.spr_r;

    irq_line_map #(.NSRC(SRC_COUNT), .NLINE(LINE_COUNT)) u_map (
        .routes_i (routes),
        .en_i     (src_en),
        .act_i    (src_act),
        .oe_o     (nxt_oe),
        .lvl_o    (nxt_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_oe    <= '0;
            irq_level <= '0;
        end else begin
            irq_oe    <= nxt_oe;
            irq_level <= nxt_lvl;
        end
    end

    AST_LEVEL_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (irq_level & ~irq_oe) == '0); // R11

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_word[5] && !cfg_word[9] && !cfg_word[13]) |=> irq_oe == '0); // R2

    AST_DRIVE_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_oe) <= SRC_COUNT); // R7
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg = '0;
    logic        bnc = 1'b0, alt = 1'b0, pf = 1'b0, spr = 1'b0, pf_clr = 1'b0;
    logic [7:0]  lvl, oe;
    int          n_chk = 0, n_fail = 0;
    logic        m_blk = 1'b0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    irq_router u_irq_router (
        .clk(clk), .rst(rst), .cfg_word(cfg), .bnc_irq_in(bnc),
        .alt_irq_in(alt), .pf_irq_in(pf), .spare_irq_in(spr),
        .pf_en_clr(pf_clr), .irq_level(lvl), .irq_oe(oe)
    );

    function automatic logic [15:0] mk(input logic [2:0] es, input logic ealt, input logic elow,
                                       input logic een, input logic [2:0] ps, input logic pen,
                                       input logic [2:0] ss, input logic sen);
        return {2'b00, sen, ss, pen, ps, een, elow, ealt, es};
    endfunction

    // returns {level, oe}
    function automatic logic [15:0] model(input logic [15:0] c, input logic b, input logic a,
                                          input logic p, input logic s, input logic blk);
        logic [7:0] m_oe, m_lv;
        logic er;
        m_oe = '0; m_lv = '0;
        er = c[3] ? a : (b ^ c[4]);
        if (c[5]) begin m_oe[c[2:0]] = 1'b1; m_lv[c[2:0]] = m_lv[c[2:0]] | er; end
        if (c[9] && !blk) begin m_oe[c[8:6]] = 1'b1; m_lv[c[8:6]] = m_lv[c[8:6]] | p; end
        if (c[13]) begin m_oe[c[12:10]] = 1'b1; m_lv[c[12:10]] = m_lv[c[12:10]] | s; end
        return {m_lv, m_oe};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual lvl/oe=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] c, input logic b, input logic a, input logic p,
                         input logic s, input logic strobe);
        @(negedge clk);
        cfg = c; bnc = b; alt = a; pf = p; spr = s; pf_clr = strobe;
        if (strobe) m_blk = 1'b1;
        @(negedge clk);
        pf_clr = 1'b0;
        if (!c[9]) m_blk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic apply_chk(input string tag, input logic [15:0] c, input logic b, input logic a,
                             input logic p, input logic s, input logic strobe);
        apply(c, b, a, p, s, strobe);
        check(tag, {lvl, oe}, model(c, b, a, p, s, m_blk));
    endtask

    initial begin
        void'($urandom(32'd12345));
        // R10: reset holds outputs low even with everything enabled and asserted
        cfg = mk(3'd1, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 3'd3, 1'b1);
        bnc = 1'b1; alt = 1'b1; pf = 1'b1; spr = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 reset", {lvl, oe}, 16'h0000);
        @(negedge clk); rst = 1'b0;

        // R1: each code reaches its own bit
        for (int c = 0; c < 8; c++)
            apply_chk("R1 route", mk(3'(c), 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0), 1, 0, 0, 0, 0);
        // R2: all disabled, inputs active
        apply_chk("R2 disabled", mk(3'd4, 1'b0, 1'b0, 1'b0, 3'd5, 1'b0, 3'd6, 1'b0), 1, 1, 1, 1, 0);
        check("R2 no drive", {lvl, oe}, 16'h0000);
        // R3: alternate input selected, bnc ignored
        apply_chk("R3 alt sel", mk(3'd3, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0), 1, 0, 0, 0, 0);
        check("R3 alt low", {lvl, oe}, 16'h0008);
        apply_chk("R3 alt high", mk(3'd3, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0), 0, 1, 0, 0, 0);
        // R4: active-low sense on bnc
        apply_chk("R4 low sense", mk(3'd5, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0), 0, 0, 0, 0, 0);
        check("R4 inverted", {lvl, oe}, 16'h2020);
        apply_chk("R4 alt no inv", mk(3'd5, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0), 0, 1, 0, 0, 0);
        // R5 / R6 fields
        apply_chk("R5 pf route", mk(3'd0, 1'b0, 1'b0, 1'b0, 3'd6, 1'b1, 3'd0, 1'b0), 0, 0, 1, 0, 0);
        apply_chk("R6 spare route", mk(3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd1, 1'b1), 0, 0, 0, 1, 0);
        // R7: three sources on one line, only one active
        apply_chk("R7 shared", mk(3'd2, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 3'd2, 1'b1), 0, 0, 0, 1, 0);
        check("R7 shared or", {lvl, oe}, 16'h0404);
        // R12: top bits ignored
        apply_chk("R12 top bits", mk(3'd6, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd7, 1'b1) | 16'hC000, 1, 0, 1, 0, 0);

        // R9: input latency three edges, config latency one
        apply(mk(3'd2, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0), 0, 0, 0, 0, 0);
        @(negedge clk); bnc = 1'b1;
        @(negedge clk); check("R9 edge1", {lvl, oe}, 16'h0004);
        @(negedge clk); check("R9 edge2", {lvl, oe}, 16'h0004);
        @(negedge clk); check("R9 edge3", {lvl, oe}, 16'h0404);
        cfg = mk(3'd2, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 3'd6, 1'b1);
        @(negedge clk); check("R9 cfg edge1", {lvl, oe}, 16'h0444);

        // R8: clear timing, persistence, re-arm
        apply(mk(3'd0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 3'd0, 1'b0), 0, 0, 1, 0, 0);
        check("R8 armed", {lvl, oe}, 16'h8080);
        pf_clr = 1'b1; @(negedge clk); pf_clr = 1'b0; m_blk = 1'b1;
        check("R8 clr edge1", {lvl, oe}, 16'h8080);
        @(negedge clk); check("R8 clr edge2", {lvl, oe}, 16'h0000);
        apply_chk("R8 stays cleared", mk(3'd0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 3'd0, 1'b0), 0, 0, 1, 0, 0);
        check("R8 still off", {lvl, oe}, 16'h0000);
        apply_chk("R8 bit low", mk(3'd0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 3'd0, 1'b0), 0, 0, 1, 0, 0);
        apply_chk("R8 rearmed", mk(3'd0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 3'd0, 1'b0), 0, 0, 1, 0, 0);
        check("R8 back on", {lvl, oe}, 16'h8080);
        // R8: a clear while bit 9 is low still takes effect
        apply_chk("R8 clr while low", mk(3'd0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 3'd0, 1'b0), 0, 0, 1, 0, 1);
        apply_chk("R8 after low clr", mk(3'd0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 3'd0, 1'b0), 0, 0, 1, 0, 0);
        check("R8 re-enabled", {lvl, oe}, 16'h8080);

        // Random: R1 R2 R7 R12 mixed
        for (int i = 0; i < 400; i++) begin
            logic [15:0] rc;
            logic [3:0]  ri;
            rc = 16'($urandom);
            ri = 4'($urandom);
            apply_chk("R1/R7 random", rc, ri[0], ri[1], ri[2], ri[3], ($urandom % 6) == 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule